// File: doc/BRIEF.md
# DRAM Command Request Arbiter

This block sits between a set of per-bank request ports and the single command path of a DRAM controller. Each port offers one request: a row or column address, a bank address, the ras/cas/we command bits, the stream handshake bits (valid, ready, first, last) and three class flags. The class flags mark a request as a plain command (activate or precharge), a read or a write. Three class-enable inputs say which of those classes the controller can take in the present cycle. Only requests that are valid and belong to an enabled class compete.

The block presents the chosen request on one output with its own valid, and takes a ready from downstream. It returns that ready to the chosen port only. Selection rotates fairly. A chosen request stays on the output for as long as it remains valid and eligible and is not taken. Once it is taken, the search starts at the port after it, so that port is considered last. If the chosen request drops valid or leaves the enabled classes, the block moves on to the next eligible port in rotation order. The output is combinational from the present requests and a small rotation state, so a new choice appears in the same cycle as the request that causes it.

Top module: `dram_req_arbiter`

## Requirements
- R1: A port is eligible only when its valid is high and at least one of its flags matches an enabled class: is_cmd with want_cmds, is_read with want_reads, or is_write with want_writes. A valid port whose flags match no enabled class is never chosen.
- R2: When no port is eligible, out_valid is 0 and every bit of req_ready is 0, whatever out_ready is.
- R3: When out_valid is 1, out_addr, out_bank, out_ras, out_cas, out_we, out_first, out_last and the three out class flags equal the fields of the chosen port in the same cycle.
- R4: While the chosen port stays eligible and out_ready is low, the same port stays chosen in the following cycles.
- R5: When the chosen port drops valid, or stops being eligible, without being taken, the choice moves to the first eligible port found by searching upward from the port after it, wrapping from port N-1 to port 0.
- R6: After a transfer (out_valid and out_ready both high), the next choice is the first eligible port searching upward from the port after the one taken, wrapping from port N-1 to port 0; the taken port is chosen again only if no other port is eligible.
- R7: req_ready has at most one bit set. The bit for port i is 1 only when port i is chosen, out_valid is 1 and out_ready is 1.
- R8: After reset the search begins at port 0, so with every port eligible the first choice is port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| want_cmds | input | 1 | Enables requests flagged is_cmd |
| want_reads | input | 1 | Enables requests flagged is_read |
| want_writes | input | 1 | Enables requests flagged is_write |
| req_valid | input | N | Per-port request valid |
| req_ready | output | N | Per-port ready, set only for the chosen port |
| req_first | input | N | Per-port first-of-packet flag |
| req_last | input | N | Per-port last-of-packet flag |
| req_addr | input | N x AW | Per-port address |
| req_bank | input | N x BW | Per-port bank address |
| req_ras | input | N | Per-port ras bit |
| req_cas | input | N | Per-port cas bit |
| req_we | input | N | Per-port we bit |
| req_is_cmd | input | N | Per-port plain-command flag |
| req_is_read | input | N | Per-port read flag |
| req_is_write | input | N | Per-port write flag |
| out_valid | output | 1 | A request is chosen |
| out_ready | input | 1 | Downstream accepts the chosen request |
| out_first | output | 1 | First flag of the chosen request |
| out_last | output | 1 | Last flag of the chosen request |
| out_addr | output | AW | Address of the chosen request |
| out_bank | output | BW | Bank address of the chosen request |
| out_ras | output | 1 | ras bit of the chosen request |
| out_cas | output | 1 | cas bit of the chosen request |
| out_we | output | 1 | we bit of the chosen request |
| out_is_cmd | output | 1 | Plain-command flag of the chosen request |
| out_is_read | output | 1 | Read flag of the chosen request |
| out_is_write | output | 1 | Write flag of the chosen request |

## Verification
On every cycle the assertions check the ready routing (one bit at most, only with out_ready and out_valid, none while idle), that a chosen port is really valid, that a stalled choice stays put while it remains eligible, and that a transfer moves the choice away from the taken port whenever another port is eligible. The exact rotation order cannot be read from those properties: only the bench's scenarios show that the search starts at port 0 after reset, wraps from the top port to port 0, skips ports whose class is disabled, and recovers from a dropped valid to the right neighbour. The bench also compares every output field against the expected port's values in each cycle.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

   // Control bits carried with each request, muxed as one vector.
   typedef struct packed {
      logic ras;
      logic cas;
      logic we;
      logic first;
      logic last;
      logic is_cmd;
      logic is_read;
      logic is_write;
   } req_ctl_t;

   localparam int CTL_W = $bits(req_ctl_t);

   // Index width that stays legal for a single port.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/arb_class_filter.sv
module arb_class_filter #(
   parameter int N = 4
) (
   input  logic         en_cmd,
   input  logic         en_read,
   input  logic         en_write,
   input  logic [N-1:0] valid,
   input  logic [N-1:0] is_cmd,
   input  logic [N-1:0] is_read,
   input  logic [N-1:0] is_write,
   output logic [N-1:0] elig
);

   initial begin
      assert (N >= 1) else $error("arb_class_filter: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_port
      logic class_hit;
      assign class_hit = (is_cmd[i]   & en_cmd)
                       | (is_read[i]  & en_read)
                       | (is_write[i] & en_write);
      assign elig[i]   = valid[i] & class_hit;
   end

endmodule

// File: rtl/arb_rr_search.sv
module arb_rr_search #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  elig,
   input  logic [IW-1:0] start,
   output logic          found,
   output logic [IW-1:0] idx
);

   initial begin
      assert (N >= 1) else $error("arb_rr_search: N must be at least 1");
      assert ((1 << IW) >= N) else $error("arb_rr_search: IW too narrow for N");
   end

   // First eligible port at or above start, wrapping to port 0.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = 0; k < N; k++) begin
         int cand;
         cand = int'(start) + k;
         if (cand >= N) cand = cand - N;
         if (!found && elig[cand]) begin
            found = 1'b1;
            idx   = IW'(cand);
         end
      end
   end

endmodule

// File: rtl/arb_onehot_mux.sv
module arb_onehot_mux #(
   parameter int N  = 4,
   parameter int DW = 8
) (
   input  logic [N-1:0]         sel,
   input  logic [N-1:0][DW-1:0] din,
   output logic [DW-1:0]        dout
);

   initial begin
      assert (DW >= 1) else $error("arb_onehot_mux: DW must be at least 1");
   end

   logic [N-1:0][DW-1:0] gated;

   for (genvar i = 0; i < N; i++) begin : g_gate
      assign gated[i] = din[i] & {DW{sel[i]}};
   end

   always_comb begin
      dout = '0;
      for (int i = 0; i < N; i++) begin
         dout = dout | gated[i];
      end
   end

endmodule

// File: rtl/dram_req_arbiter.sv
module dram_req_arbiter
   import dram_arb_pkg::*;
#(
   parameter int N  = 4,
   parameter int AW = 14,
   parameter int BW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 want_cmds,
   input  logic                 want_reads,
   input  logic                 want_writes,
   input  logic [N-1:0]         req_valid,
   output logic [N-1:0]         req_ready,
   input  logic [N-1:0]         req_first,
   input  logic [N-1:0]         req_last,
   input  logic [N-1:0][AW-1:0] req_addr,
   input  logic [N-1:0][BW-1:0] req_bank,
   input  logic [N-1:0]         req_ras,
   input  logic [N-1:0]         req_cas,
   input  logic [N-1:0]         req_we,
   input  logic [N-1:0]         req_is_cmd,
   input  logic [N-1:0]         req_is_read,
   input  logic [N-1:0]         req_is_write,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic                 out_first,
   output logic                 out_last,
   output logic [AW-1:0]        out_addr,
   output logic [BW-1:0]        out_bank,
   output logic                 out_ras,
   output logic                 out_cas,
   output logic                 out_we,
   output logic                 out_is_cmd,
   output logic                 out_is_read,
   output logic                 out_is_write
);

   localparam int          IW       = idx_width(N);
   localparam int          DW       = AW + BW + CTL_W;
   localparam logic [IW-1:0] LAST_IX = IW'(N - 1);
   localparam logic [N-1:0]  ONE     = N'(1);

   initial begin
      assert (N >= 2)  else $error("dram_req_arbiter: N must be at least 2");
      assert (AW >= 1) else $error("dram_req_arbiter: AW must be at least 1");
      assert (BW >= 1) else $error("dram_req_arbiter: BW must be at least 1");
   end

   // ---------------------------------------------------------------
   // Class filter
   // ---------------------------------------------------------------
   logic [N-1:0] elig;

   arb_class_filter #(.N(N)) u_filter (
      .en_cmd   (want_cmds),
      .en_read  (want_reads),
      .en_write (want_writes),
      .valid    (req_valid),
      .is_cmd   (req_is_cmd),
      .is_read  (req_is_read),
      .is_write (req_is_write),
      .elig     (elig)
   );

   // ---------------------------------------------------------------
   // Rotation state: last chosen port and whether it is being held
   // ---------------------------------------------------------------
   logic [IW-1:0] last_q;
   logic          held_q;
   logic [IW-1:0] after_last;
   logic [IW-1:0] search_from;
   logic          any_elig;
   logic [IW-1:0] sel_idx;

   assign after_last  = (last_q == LAST_IX) ? '0 : last_q + IW'(1);
   assign search_from = (held_q && elig[last_q]) ? last_q : after_last;

   arb_rr_search #(.N(N), .IW(IW)) u_search (
      .elig  (elig),
      .start (search_from),
      .found (any_elig),
      .idx   (sel_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= LAST_IX;
         held_q <= 1'b0;
      end else if (any_elig) begin
         last_q <= sel_idx;
         held_q <= !out_ready;
      end else begin
         held_q <= 1'b0;
      end
   end

   // ---------------------------------------------------------------
   // Data path
   // ---------------------------------------------------------------
   logic [N-1:0]         sel_oh;
   logic [N-1:0][DW-1:0] packed_req;
   logic [DW-1:0]        packed_out;
   req_ctl_t             ctl_out;

   for (genvar i = 0; i < N; i++) begin : g_pack
      req_ctl_t ctl_i;
      assign ctl_i.ras      = req_ras[i];
      assign ctl_i.cas      = req_cas[i];
      assign ctl_i.we       = req_we[i];
      assign ctl_i.first    = req_first[i];
      assign ctl_i.last     = req_last[i];
      assign ctl_i.is_cmd   = req_is_cmd[i];
      assign ctl_i.is_read  = req_is_read[i];
      assign ctl_i.is_write = req_is_write[i];
      assign packed_req[i]  = {req_addr[i], req_bank[i], ctl_i};
      assign sel_oh[i]      = any_elig && (sel_idx == IW'(i));
      assign req_ready[i]   = sel_oh[i] & out_ready;
   end

   arb_onehot_mux #(.N(N), .DW(DW)) u_mux (
      .sel  (sel_oh),
      .din  (packed_req),
      .dout (packed_out)
   );

   assign {out_addr, out_bank, ctl_out} = packed_out;
   assign out_valid    = any_elig;
   assign out_ras      = ctl_out.ras;
   assign out_cas      = ctl_out.cas;
   assign out_we       = ctl_out.we;
   assign out_first    = ctl_out.first;
   assign out_last     = ctl_out.last;
   assign out_is_cmd   = ctl_out.is_cmd;
   assign out_is_read  = ctl_out.is_read;
   assign out_is_write = ctl_out.is_write;

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   assert_ready_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   assert_ready_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_ready) |-> (out_ready && out_valid));

   assert_idle_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (req_ready == '0));

   assert_chosen_is_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> req_valid[sel_idx]);

   assert_hold_when_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (!elig[$past(sel_idx)] || sel_idx == $past(sel_idx)));

   assert_move_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=>
         (!out_valid || sel_idx != $past(sel_idx) || elig == (ONE << $past(sel_idx))));

endmodule

// File: tb/sim_dram_req_arbiter.sv
module sim_dram_req_arbiter;

   localparam int  N          = 4;
   localparam int  AW         = 14;
   localparam int  BW         = 3;
   localparam time CLK_PERIOD = 10ns;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 want_cmds = 1'b0, want_reads = 1'b0, want_writes = 1'b0;
   logic [N-1:0]         req_valid = '0, req_ready;
   logic [N-1:0]         req_first = '0, req_last = '0;
   logic [N-1:0][AW-1:0] req_addr;
   logic [N-1:0][BW-1:0] req_bank;
   logic [N-1:0]         req_ras = '0, req_cas = '0, req_we = '0;
   logic [N-1:0]         req_is_cmd = '0, req_is_read = '0, req_is_write = '0;
   logic                 out_valid, out_ready = 1'b0;
   logic                 out_first, out_last;
   logic [AW-1:0]        out_addr;
   logic [BW-1:0]        out_bank;
   logic                 out_ras, out_cas, out_we;
   logic                 out_is_cmd, out_is_read, out_is_write;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dram_req_arbiter #(.N(N), .AW(AW), .BW(BW)) u0 (
      .clk, .rst_n, .want_cmds, .want_reads, .want_writes,
      .req_valid, .req_ready, .req_first, .req_last, .req_addr, .req_bank,
      .req_ras, .req_cas, .req_we, .req_is_cmd, .req_is_read, .req_is_write,
      .out_valid, .out_ready, .out_first, .out_last, .out_addr, .out_bank,
      .out_ras, .out_cas, .out_we, .out_is_cmd, .out_is_read, .out_is_write
   );

   typedef struct {
      logic         valid;
      int           port;
      logic [N-1:0] ready;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   // Bench-side rotation model, derived from R5, R6 and R8.
   int   m_last = N - 1;
   bit   m_held = 1'b0;

   // Fixed per-port fields: bank = port, addr = 100 + port,
   // ras = port bit 0, cas = port bit 1, we = 1 for port 3, first = 1, last = 0.
   initial begin
      for (int i = 0; i < N; i++) begin
         req_addr[i]  = AW'(100 + i);
         req_bank[i]  = BW'(i);
         req_ras[i]   = 1'(i & 1);
         req_cas[i]   = 1'((i >> 1) & 1);
         req_we[i]    = (i == 3);
         req_first[i] = 1'b1;
      end
   end

   task automatic fail(input string tag, input string what, input int act, input int expv);
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
   endtask

   task automatic cyc(input logic [N-1:0] v, input logic [N-1:0] c,
                      input logic [N-1:0] r, input logic [N-1:0] w,
                      input logic wc, input logic wr, input logic ww,
                      input logic rdy, input string tag);
      logic [N-1:0] el;
      int           start;
      exp_t         e;
      @(negedge clk);
      req_valid = v; req_is_cmd = c; req_is_read = r; req_is_write = w;
      want_cmds = wc; want_reads = wr; want_writes = ww; out_ready = rdy;
      for (int i = 0; i < N; i++)
         el[i] = v[i] & ((c[i] & wc) | (r[i] & wr) | (w[i] & ww));
      start   = (m_held && el[m_last]) ? m_last : (m_last + 1) % N;
      e.valid = 1'b0;
      e.port  = 0;
      e.ready = '0;
      e.tag   = tag;
      for (int k = 0; k < N; k++) begin
         int p;
         p = (start + k) % N;
         if (!e.valid && el[p]) begin
            e.valid = 1'b1;
            e.port  = p;
         end
      end
      if (e.valid && rdy) e.ready[e.port] = 1'b1;
      exp_q.push_back(e);
      if (e.valid) begin
         m_last = e.port;
         m_held = !rdy;
      end else begin
         m_held = 1'b0;
      end
   endtask

   // Monitor: samples a quarter period after the driving edge.
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD / 4);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (out_valid !== e.valid)
               fail(e.tag, "out_valid", int'(out_valid), int'(e.valid));
            else if (req_ready !== e.ready)
               fail(e.tag, "req_ready", int'(req_ready), int'(e.ready));
            else if (e.valid) begin
               // R3: every field comes from the chosen port
               if (out_bank !== BW'(e.port))
                  fail(e.tag, "out_bank", int'(out_bank), e.port);
               else if (out_addr !== AW'(100 + e.port))
                  fail("R3", "out_addr", int'(out_addr), 100 + e.port);
               else if ({out_ras, out_cas, out_we, out_first, out_last} !==
                        {1'(e.port & 1), 1'((e.port >> 1) & 1), e.port == 3, 1'b1, 1'b0})
                  fail("R3", "ctl bits", int'({out_ras, out_cas, out_we, out_first, out_last}), e.port);
               else if ({out_is_cmd, out_is_read, out_is_write} !==
                        {req_is_cmd[e.port], req_is_read[e.port], req_is_write[e.port]})
                  fail("R3", "class flags", int'({out_is_cmd, out_is_read, out_is_write}), e.port);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: outputs while reset is held (R2)
      #(CLK_PERIOD / 4);
      checks++;
      if (out_valid !== 1'b0 || req_ready !== '0)
         fail("R2", "reset outputs", int'({out_valid, req_ready}), 0);
      rst_n = 1'b1;

      // R2: nothing valid
      cyc(4'b0000, 4'b1111, 4'b0000, 4'b0000, 1, 1, 1, 1, "R2");
      // R8: all plain commands eligible, first choice is port 0
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 0, "R8");
      // R4: stalled choice holds
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 0, "R4");
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 0, "R4");
      // R5: port 0 drops valid, choice goes to port 1
      cyc(4'b1110, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 0, "R5");
      // R7: taken, ready only to port 1
      cyc(4'b1110, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 1, "R7");
      // R6: next after port 1
      cyc(4'b1110, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 0, "R6");
      // R1: classes mixed, only reads enabled (port 2 read, port 3 write)
      cyc(4'b1111, 4'b0011, 4'b0100, 4'b1000, 0, 1, 0, 0, "R1");
      // R1/R5: only writes enabled, held port leaves the class, port 3 taken
      cyc(4'b1111, 4'b0011, 4'b0100, 4'b1000, 0, 0, 1, 1, "R1");
      // R6: wrap from port 3 to port 0
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 0, "R6");
      // R2: valid requests but no class enabled, out_ready high
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 0, 0, 0, 1, "R2");
      // R6: continuous transfers rotate through every port
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 1, "R6");
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 1, "R6");
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 1, "R6");
      cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 1, "R6");
      // R6: only the taken port eligible, it is chosen again
      cyc(4'b0100, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 1, "R6");
      cyc(4'b0100, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 1, "R6");
      // R1: reads offered while only commands enabled are ignored
      cyc(4'b1111, 4'b0000, 4'b1111, 4'b0000, 1, 0, 0, 1, "R1");
      // R7: stalled choice gets no ready
      cyc(4'b1010, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 0, "R7");
      cyc(4'b1010, 4'b1111, 4'b0000, 4'b0000, 1, 0, 0, 1, "R7");
      cyc(4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 0, 0, "R2");

      wait (exp_q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule